// File: doc/BRIEF.md
# Dual-Tone Digital Sine Synthesizer

This block turns a 4-bit keypad digit code into a pair of digital sine streams, one from the low (row) group and one from the high (column) group, and adds them into a single signed sample word. Each of the two channels has a segment divider that counts master-clock cycles. The divider is loaded from a one-hot row line or a one-hot column line, so that exactly two of eight lines are active. When the divider reaches its terminal count it restarts and advances a 32-step phase counter. The phase counter addresses a sine table. Because every tone period is exactly 32 segments long, the frequency is set only by the segment length. With the default divisors and a 3.579545 MHz master clock, the row tones come out at about 699.1, 766.2, 847.4 and 948.0 Hz, and the column tones at about 1215.9, 1331.7, 1471.9 and 1645.0 Hz.

A small sequencer controls the two channels. It has three states:
- `ST_OFF`: the block is idle and the output is zero.
- `ST_ARM`: the block captures the digit code and clears both channels.
- `ST_RUN`: the channels count and the output follows them.

It has these transitions:
- *enable-on*: `ST_OFF` to `ST_ARM`.
- *start*: `ST_ARM` to `ST_RUN`.
- *digit-change*: `ST_RUN` to `ST_ARM`, when the input code differs from the captured code.
- *disable*: from any state to `ST_OFF`, when the enable is low.

A single-tone select passes only one channel to the output, and the column/row select chooses which one. The column channel is weighted slightly heavier than the row channel, which gives about 2 dB of twist. The sum is clamped into a 10-bit signed word. A strobe marks each cycle in which the word reflects a fresh phase step of a channel that is being output.

Top module: `dual_tone_synth`

## Requirements
- R1: While reset is asserted, and after it is released with the enable low, `sample_out` is 0 and `sample_vld` is 0.
- R2: The digit code selects one row line and one column line as follows. Row 0 is selected by 0001, 0010, 0011 and 1101. Row 1 by 0100, 0101, 0110 and 1110. Row 2 by 0111, 1000, 1001 and 1111. Row 3 by 1011, 1010, 1100 and 0000. Within each group of four, the codes select columns 0, 1, 2 and 3 in the order given. Exactly one row line and one column line are active.
- R3: The segment divisors are 160, 146, 132 and 118 cycles for rows 0 to 3, and 92, 84, 76 and 68 cycles for columns 0 to 3. In single-tone mode, successive strobes are exactly one divisor of the selected channel apart.
- R4: Each tone period spans 32 segments. At phase k the table gives round(127·sin(2πk/32)), and the phase wraps from 31 to 0.
- R5: In dual mode, the output is clamp(4·row_sample + 5·col_sample). A strobe occurs in every cycle in which either channel has just stepped, with a fixed latency of one cycle after the stepped phase.
- R6: In single-tone mode, `col_sel`=1 outputs only clamp(5·col_sample) and `col_sel`=0 outputs only 4·row_sample. Strobes come only from the channel being output.
- R7: One clock edge after `tone_en` is sampled low, `sample_out` is 0 and `sample_vld` is 0. While the enable stays low, changes of the digit code produce no strobe and no output.
- R8: Raising the enable, or changing the digit code while running, restarts both phase counters at 0. Until the first strobe after a restart the output is 0, and the first strobe carries the value for phase 1.
- R9: The sum is clamped to the range −512 to 511. A lone column tone at its peak gives 511, and at its trough gives −512.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tone_en | input | 1 | Tone enable; low silences the output and clears both channels |
| digit_code | input | 4 | Keypad digit code selecting the row and column tones |
| single_tone | input | 1 | 1: output one channel only; 0: output both channels summed |
| col_sel | input | 1 | In single-tone mode, 1 selects the column tone and 0 the row tone |
| sample_out | output | 10 | Signed composite sample word |
| sample_vld | output | 1 | One-cycle strobe when `sample_out` reflects a new phase step |

## Verification
The embedded properties check the following on every cycle:
- The segment counter stays below the selected divisor.
- A divider tick advances the phase by exactly one.
- Exactly two of the eight select lines are active.
- An arm cycle leaves both phases at zero.
- Every strobe is backed by a channel tick two cycles earlier.
- A low enable silences the output on the next edge.

Only the bench's scenarios can show the following:
- The spacing of the strobes per digit.
- The exact sample values through a full 32-step wrap.
- The clamping at the peaks.
- The restart when the digit changes.
- That digit changes are ignored while the block is disabled.

// File: rtl/dts_pkg.sv
package dts_pkg;

    localparam int N_LINES        = 4;
    localparam int SEG_PER_PERIOD = 32;
    localparam int PHASE_W        = $clog2(SEG_PER_PERIOD);
    localparam int LUT_W          = 8;

    typedef enum logic [1:0] {
        ST_OFF = 2'd0,
        ST_ARM = 2'd1,
        ST_RUN = 2'd2
    } seq_state_e;

    typedef logic [PHASE_W-1:0]      phase_t;
    typedef logic signed [LUT_W-1:0] lut_t;

    // First quarter of a 32-step sine wave scaled to 127.
    function automatic lut_t quarter_wave(input logic [3:0] m);
        lut_t v;
        case (m)
            4'd0:    v = 8'sd0;
            4'd1:    v = 8'sd25;
            4'd2:    v = 8'sd49;
            4'd3:    v = 8'sd71;
            4'd4:    v = 8'sd90;
            4'd5:    v = 8'sd106;
            4'd6:    v = 8'sd117;
            4'd7:    v = 8'sd125;
            4'd8:    v = 8'sd127;
            default: v = 8'sd0;
        endcase
        return v;
    endfunction

    // Full-period lookup built from quarter-wave symmetry.
    function automatic lut_t sine_at(input phase_t ph);
        logic [4:0] k;
        logic [4:0] m;
        lut_t       mag;
        k   = {1'b0, ph[3:0]};
        m   = (k > 5'd8) ? (5'd16 - k) : k;
        mag = quarter_wave(m[3:0]);
        return ph[4] ? -mag : mag;
    endfunction

endpackage

// File: rtl/dts_keymap.sv
module dts_keymap
    import dts_pkg::*;
(
    input  logic [3:0]         digit,
    output logic [N_LINES-1:0] row_oh,
    output logic [N_LINES-1:0] col_oh
);

    logic [1:0] row_idx;
    logic [1:0] col_idx;

    always_comb begin
        unique case (digit)
            4'd0:  begin row_idx = 2'd3; col_idx = 2'd3; end
            4'd1:  begin row_idx = 2'd0; col_idx = 2'd0; end
            4'd2:  begin row_idx = 2'd0; col_idx = 2'd1; end
            4'd3:  begin row_idx = 2'd0; col_idx = 2'd2; end
            4'd4:  begin row_idx = 2'd1; col_idx = 2'd0; end
            4'd5:  begin row_idx = 2'd1; col_idx = 2'd1; end
            4'd6:  begin row_idx = 2'd1; col_idx = 2'd2; end
            4'd7:  begin row_idx = 2'd2; col_idx = 2'd0; end
            4'd8:  begin row_idx = 2'd2; col_idx = 2'd1; end
            4'd9:  begin row_idx = 2'd2; col_idx = 2'd2; end
            4'd10: begin row_idx = 2'd3; col_idx = 2'd1; end
            4'd11: begin row_idx = 2'd3; col_idx = 2'd0; end
            4'd12: begin row_idx = 2'd3; col_idx = 2'd2; end
            4'd13: begin row_idx = 2'd0; col_idx = 2'd3; end
            4'd14: begin row_idx = 2'd1; col_idx = 2'd3; end
            default: begin row_idx = 2'd2; col_idx = 2'd3; end
        endcase
    end

    // Expand the two indices into the 2-of-8 line form.
    for (genvar i = 0; i < N_LINES; i++) begin : g_lines
        assign row_oh[i] = (row_idx == 2'(i));
        assign col_oh[i] = (col_idx == 2'(i));
    end

endmodule

// File: rtl/dts_tone_ch.sv
module dts_tone_ch
    import dts_pkg::*;
#(
    parameter int          SEG_W = 8,
    parameter int          GAIN  = 4,
    parameter int          AMP_W = 12,
    parameter int unsigned DIVS [N_LINES] = '{160, 146, 132, 118}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run,
    input  logic                    clr,
    input  logic [N_LINES-1:0]      sel_oh,
    output logic                    tick,
    output phase_t                  phase,
    output logic signed [AMP_W-1:0] amp
);

    localparam logic signed [AMP_W-1:0] GAIN_S = AMP_W'(GAIN);

    logic [SEG_W-1:0] div;
    logic [SEG_W-1:0] seg_cnt;
    lut_t             raw;

    // Divisor picked by the active select line.
    always_comb begin
        div = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (sel_oh[i]) begin
                div = div | SEG_W'(DIVS[i]);
            end
        end
    end

    assign tick = run && (seg_cnt == (div - SEG_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_cnt <= '0;
            phase   <= '0;
        end else if (clr) begin
            seg_cnt <= '0;
            phase   <= '0;
        end else if (run) begin
            if (tick) begin
                seg_cnt <= '0;
                phase   <= phase + phase_t'(1);
            end else begin
                seg_cnt <= seg_cnt + SEG_W'(1);
            end
        end
    end

    assign raw = sine_at(phase);
    assign amp = AMP_W'(raw) * GAIN_S;

    // R3: segment counter never passes the terminal count
    a_r3_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (seg_cnt < div));

    // R4: each terminal count moves the table address one step
    a_r4_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (phase == $past(phase) + phase_t'(1)));

endmodule

// File: rtl/dts_mixer.sv
module dts_mixer #(
    parameter int AMP_W = 12,
    parameter int OUT_W = 10
) (
    input  logic signed [AMP_W-1:0] row_amp,
    input  logic signed [AMP_W-1:0] col_amp,
    input  logic                    single,
    input  logic                    col_sel,
    output logic signed [OUT_W-1:0] mix
);

    localparam int SUM_W = AMP_W + 1;
    localparam logic signed [SUM_W-1:0] HI = SUM_W'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] LO = SUM_W'(-(2 ** (OUT_W - 1)));

    logic signed [SUM_W-1:0] r_ext;
    logic signed [SUM_W-1:0] c_ext;
    logic signed [SUM_W-1:0] sum;

    assign r_ext = SUM_W'(row_amp);
    assign c_ext = SUM_W'(col_amp);

    always_comb begin
        if (single) begin
            sum = col_sel ? c_ext : r_ext;
        end else begin
            sum = r_ext + c_ext;
        end
        if (sum > HI) begin
            mix = HI[OUT_W-1:0];
        end else if (sum < LO) begin
            mix = LO[OUT_W-1:0];
        end else begin
            mix = sum[OUT_W-1:0];
        end
    end

endmodule

// File: rtl/dual_tone_synth.sv
module dual_tone_synth
    import dts_pkg::*;
#(
    parameter int          OUT_W    = 10,
    parameter int          SEG_W    = 8,
    parameter int          ROW_GAIN = 4,
    parameter int          COL_GAIN = 5,
    parameter int unsigned ROW_DIV [N_LINES] = '{160, 146, 132, 118},
    parameter int unsigned COL_DIV [N_LINES] = '{92, 84, 76, 68}
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    tone_en,
    input  logic [3:0]              digit_code,
    input  logic                    single_tone,
    input  logic                    col_sel,
    output logic signed [OUT_W-1:0] sample_out,
    output logic                    sample_vld
);

    localparam int AMP_W = OUT_W + 2;

    seq_state_e state_q;
    seq_state_e state_d;
    logic [3:0] held_code;

    logic [N_LINES-1:0]      row_oh;
    logic [N_LINES-1:0]      col_oh;
    logic                    run;
    logic                    clr;
    logic                    tick_r;
    logic                    tick_c;
    logic                    tick_sel;
    logic                    tick_q;
    phase_t                  phase_r;
    phase_t                  phase_c;
    logic signed [AMP_W-1:0] amp_r;
    logic signed [AMP_W-1:0] amp_c;
    logic signed [OUT_W-1:0] mix;

    // Next-state logic of the sequencer.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: if (tone_en) state_d = ST_ARM;
            ST_ARM: state_d = tone_en ? ST_RUN : ST_OFF;
            ST_RUN: begin
                if (!tone_en) begin
                    state_d = ST_OFF;
                end else if (digit_code != held_code) begin
                    state_d = ST_ARM;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register; the digit is captured on entry to ST_ARM.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_OFF;
            held_code <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_ARM) begin
                held_code <= digit_code;
            end
        end
    end

    assign run = (state_q == ST_RUN);
    assign clr = !run;

    dts_keymap u_keymap (
        .digit  (held_code),
        .row_oh (row_oh),
        .col_oh (col_oh)
    );

    dts_tone_ch #(
        .SEG_W (SEG_W),
        .GAIN  (ROW_GAIN),
        .AMP_W (AMP_W),
        .DIVS  (ROW_DIV)
    ) u_row (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .clr    (clr),
        .sel_oh (row_oh),
        .tick   (tick_r),
        .phase  (phase_r),
        .amp    (amp_r)
    );

    dts_tone_ch #(
        .SEG_W (SEG_W),
        .GAIN  (COL_GAIN),
        .AMP_W (AMP_W),
        .DIVS  (COL_DIV)
    ) u_col (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .clr    (clr),
        .sel_oh (col_oh),
        .tick   (tick_c),
        .phase  (phase_c),
        .amp    (amp_c)
    );

    dts_mixer #(
        .AMP_W (AMP_W),
        .OUT_W (OUT_W)
    ) u_mix (
        .row_amp (amp_r),
        .col_amp (amp_c),
        .single  (single_tone),
        .col_sel (col_sel),
        .mix     (mix)
    );

    always_comb begin
        if (single_tone) begin
            tick_sel = col_sel ? tick_c : tick_r;
        end else begin
            tick_sel = tick_r | tick_c;
        end
    end

    // Output register and strobe pipeline.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sample_out <= '0;
            sample_vld <= 1'b0;
            tick_q     <= 1'b0;
        end else if (!tone_en || (state_q != ST_RUN)) begin
            sample_out <= '0;
            sample_vld <= 1'b0;
            tick_q     <= 1'b0;
        end else begin
            sample_out <= mix;
            tick_q     <= tick_sel;
            sample_vld <= tick_q;
        end
    end

    // R2: exactly one row line and one column line
    a_r2_two_of_eight: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(row_oh) == 1) && ($countones(col_oh) == 1));

    // R7: a low enable silences the word on the next edge
    a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !tone_en |=> ((sample_out == '0) && !sample_vld));

    // R8: an arm cycle restarts both phase counters
    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARM) |=> ((phase_r == '0) && (phase_c == '0)));

    // R5: every strobe traces back to a channel tick
    a_r5_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld |-> $past(tick_r | tick_c, 2));

endmodule

// File: tb/dual_tone_synth_test.sv
`timescale 1ns/1ps
module dual_tone_synth_test;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              tone_en = 1'b0;
    logic [3:0]        digit_code = 4'd0;
    logic              single_tone = 1'b0;
    logic              col_sel = 1'b0;
    logic signed [9:0] sample_out;
    logic              sample_vld;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2.5 clk = ~clk;

    dual_tone_synth uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tone_en     (tone_en),
        .digit_code  (digit_code),
        .single_tone (single_tone),
        .col_sel     (col_sel),
        .sample_out  (sample_out),
        .sample_vld  (sample_vld)
    );

    // digit code, row divisor, column divisor (R2, R3)
    localparam logic [19:0] VEC [16] = '{
        {4'd0,  8'd118, 8'd68}, {4'd1,  8'd160, 8'd92},
        {4'd2,  8'd160, 8'd84}, {4'd3,  8'd160, 8'd76},
        {4'd4,  8'd146, 8'd92}, {4'd5,  8'd146, 8'd84},
        {4'd6,  8'd146, 8'd76}, {4'd7,  8'd132, 8'd92},
        {4'd8,  8'd132, 8'd84}, {4'd9,  8'd132, 8'd76},
        {4'd10, 8'd118, 8'd84}, {4'd11, 8'd118, 8'd92},
        {4'd12, 8'd118, 8'd76}, {4'd13, 8'd160, 8'd68},
        {4'd14, 8'd146, 8'd68}, {4'd15, 8'd132, 8'd68}
    };

    function automatic int ref_sine(int k);
        real x;
        x = 127.0 * $sin(2.0 * 3.14159265358979 * k / 32.0);
        return int'($floor(x + 0.5));
    endfunction

    function automatic int clamp(int v);
        if (v > 511) return 511;
        if (v < -512) return -512;
        return v;
    endfunction

    function automatic int model_out(int t, bit sgl, bit cs, int rd, int cd);
        int r;
        int c;
        r = 4 * ref_sine((t / rd) % 32);
        c = 5 * ref_sine((t / cd) % 32);
        if (sgl) return clamp(cs ? c : r);
        return clamp(r + c);
    endfunction

    function automatic bit model_vld(int t, bit sgl, bit cs, int rd, int cd);
        if (sgl) return cs ? (t % cd == 0) : (t % rd == 0);
        return (t % rd == 0) || (t % cd == 0);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Start a digit (or switch it live) and compare every cycle against the model.
    task automatic run_window(input logic [3:0] code, input bit sgl, input bit cs,
                              input int rd, input int cd, input int ncyc,
                              input bit live, input string req,
                              output int omax, output int omin);
        int  dsel;
        int  t;
        int  w;
        int  bad;
        int  fa;
        int  fe;
        int  fav;
        int  fev;
        int  ft;
        int  eo;
        bit  ev;
        bad = 0; fa = 0; fe = 0; fav = 0; fev = 0; ft = 0;
        omax = -1000; omin = 1000;
        if (!live) begin
            tone_en = 1'b0;
            repeat (3) @(negedge clk);
        end
        digit_code  = code;
        single_tone = sgl;
        col_sel     = cs;
        tone_en     = 1'b1;
        repeat (3) @(negedge clk);
        dsel = sgl ? (cs ? cd : rd) : ((rd < cd) ? rd : cd);
        w = 0;
        while (!sample_vld && w < 400) begin
            if (sample_out != 0) begin
                if (bad == 0) begin fa = sample_out; fe = 0; ft = -1; end
                bad++;
            end
            @(negedge clk);
            w++;
        end
        if (w >= 400) begin
            bad++;
            fa = 0; fe = 1; ft = -2;
        end
        t = dsel;
        for (int k = 0; k < ncyc; k++) begin
            eo = model_out(t, sgl, cs, rd, cd);
            ev = model_vld(t, sgl, cs, rd, cd);
            if (int'(sample_out) > omax) omax = sample_out;
            if (int'(sample_out) < omin) omin = sample_out;
            if (int'(sample_out) != eo || sample_vld != ev) begin
                if (bad == 0) begin
                    fa = sample_out; fe = eo; fav = sample_vld; fev = ev; ft = t;
                end
                bad++;
            end
            @(negedge clk);
            t++;
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s digit %0d: t=%0d out/vld actual %0d/%0d expected %0d/%0d (%0d mismatches)",
                     req, code, ft, fa, fav, fe, fev, bad);
        end
    endtask

    initial begin
        int mx;
        int mn;
        int bad;
        repeat (3) @(negedge clk);
        // R1: reset state while reset held
        check(sample_out == 0 && !sample_vld, "R1 in reset", int'(sample_out), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(sample_out == 0 && !sample_vld, "R1 after release", int'(sample_out), 0);

        // R2/R5: every digit in dual mode, walked from the vector table
        for (int i = 0; i < 16; i++) begin
            run_window(VEC[i][19:16], 1'b0, 1'b0, int'(VEC[i][15:8]), int'(VEC[i][7:0]),
                       600, 1'b0, "R2/R5 dual", mx, mn);
        end

        // R3/R6: single row tone on each row
        run_window(4'd1,  1'b1, 1'b0, 160, 92, 500, 1'b0, "R3/R6 row", mx, mn);
        run_window(4'd4,  1'b1, 1'b0, 146, 92, 500, 1'b0, "R3/R6 row", mx, mn);
        run_window(4'd7,  1'b1, 1'b0, 132, 92, 500, 1'b0, "R3/R6 row", mx, mn);
        run_window(4'd11, 1'b1, 1'b0, 118, 92, 500, 1'b0, "R3/R6 row", mx, mn);
        // R3/R6: single column tone on each column
        run_window(4'd1,  1'b1, 1'b1, 160, 92, 400, 1'b0, "R3/R6 col", mx, mn);
        run_window(4'd2,  1'b1, 1'b1, 160, 84, 400, 1'b0, "R3/R6 col", mx, mn);
        run_window(4'd3,  1'b1, 1'b1, 160, 76, 400, 1'b0, "R3/R6 col", mx, mn);

        // R9: lone column tone over a full period reaches both clamp limits
        run_window(4'd13, 1'b1, 1'b1, 160, 68, 32 * 68 + 20, 1'b0, "R9 col window", mx, mn);
        check(mx == 511, "R9 peak", mx, 511);
        check(mn == -512, "R9 trough", mn, -512);

        // R4: a full 32-segment row period with wrap, dual mode
        run_window(4'd1, 1'b0, 1'b0, 160, 92, 32 * 160 + 200, 1'b0, "R4 wrap", mx, mn);

        // R8: live digit change restarts both channels
        run_window(4'd5, 1'b0, 1'b0, 146, 84, 300, 1'b0, "R5 before change", mx, mn);
        run_window(4'd9, 1'b0, 1'b0, 132, 76, 600, 1'b1, "R8 live change", mx, mn);

        // R7: disable mid-run silences the word after one edge
        @(negedge clk);
        tone_en = 1'b0;
        @(negedge clk);
        check(sample_out == 0 && !sample_vld, "R7 disable", int'(sample_out), 0);

        // R7: code changes while disabled have no effect at the ports
        bad = 0;
        for (int k = 0; k < 300; k++) begin
            if (k % 20 == 0) digit_code = 4'(k / 20);
            if (sample_out != 0 || sample_vld) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R7 ignore while off", bad, 0);

        // R8: enable restart after idle gives phase-1 strobe first
        run_window(4'd0, 1'b0, 1'b0, 118, 68, 300, 1'b0, "R8 re-enable", mx, mn);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule